// File: doc/BRIEF.md
# PC Card Socket Address-Window Bridge

This block sits between a processor's memory-mapped bus and one removable-card socket. The host sees the socket as a single region, and the top two bits of the region offset pick one of four equal windows. Three windows reach the card: I/O space, attribute memory and common memory. The fourth window is a reserved hole. An accepted access goes out on the card side as a one-cycle strobe. The strobe carries the address relative to the window, a two-bit code that names the space, and the write data. A card read returns data on the same cycle as the strobe, and the bridge hands that data back to the host one cycle later.

The bridge also keeps the socket's presence state. Insert and remove events arrive as one-cycle pulses. Each event is either applied or rejected with a one-cycle error flag. The card-detect interrupt follows insertion and removal. The card's own interrupt request is forwarded to the host only while a card is present. While the slot is empty, every access is masked: reads return zero and writes are dropped.

A static socket index tells the two sockets of a pair apart. It is derived from the base address parameter.

Top module: `pccard_window_bridge`

## Requirements
- R1: Bits [CARD_AW+1:CARD_AW] of the host address select the window. Value 0 selects I/O space (card code 2'b00), 2 selects attribute memory (code 2'b01) and 3 selects common memory (code 2'b10). Value 1 is reserved.
- R2: The card address is the host address with the window base removed (the low CARD_AW bits). Write data reaches the card unchanged.
- R3: A request is accepted when host_req_valid and host_req_ready are both high. The card strobe appears in the cycle after acceptance. host_rsp_valid pulses for one cycle in the cycle after that, for every accepted request, and carries zero for writes.
- R4: While slot_present is 0, no access in any space raises card_stb, and every read returns 0.
- R5: An access to the reserved window raises no card strobe, and a read of it returns 0.
- R6: An insert pulse on an empty slot sets slot_present and cd_irq on the next cycle, with slot_err low.
- R7: An insert pulse while a card is present raises slot_err for exactly one cycle and leaves slot_present and cd_irq unchanged.
- R8: A remove pulse while a card is present clears slot_present, and drives cd_irq and host_card_irq low on the next cycle.
- R9: A remove pulse on an empty slot raises slot_err for exactly one cycle and leaves the slot empty.
- R10: While a card is present, host_card_irq follows card_irq_in one cycle later. While the slot is empty it stays low.
- R11: socket_index is 1 when SOCKET_BASE equals 32'h3000_0000 and 0 for any other base.
- R12: After reset, slot_present, cd_irq, host_card_irq, slot_err, card_stb and host_rsp_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Bridge can accept a request |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | CARD_AW+2 | Offset inside the socket region |
| host_req_wdata | input | DATA_W | Host write data |
| host_rsp_valid | output | 1 | One-cycle response pulse |
| host_rsp_rdata | output | DATA_W | Read data (0 for writes and masked reads) |
| card_stb | output | 1 | One-cycle card access strobe |
| card_we | output | 1 | Card access is a write |
| card_space | output | 2 | Space code: 00 I/O, 01 attribute, 10 common |
| card_addr | output | CARD_AW | Window-relative card address |
| card_wdata | output | DATA_W | Card write data |
| card_rdata | input | DATA_W | Card read data, valid while card_stb is high |
| card_irq_in | input | 1 | Card interrupt request level |
| slot_insert | input | 1 | Card insert event pulse |
| slot_eject | input | 1 | Card remove event pulse |
| slot_err | output | 1 | One-cycle error flag for a rejected event |
| slot_present | output | 1 | A card is in the slot |
| cd_irq | output | 1 | Card-detect interrupt |
| host_card_irq | output | 1 | Card interrupt forwarded to the host |
| socket_index | output | 1 | Socket number derived from SOCKET_BASE |

## Verification
The bench builds the bridge with CARD_AW = 6, so the whole socket region is only 256 addresses wide. Every address is written and then read, once with the slot empty and once with a card inserted. This covers every window edge, the reserved hole and the masking rule without sampling. A second instance keeps the default base, and the main instance uses base 32'h3000_0000, so both socket indices are checked. The insert and remove sequences cover the rejected cases and interrupt forwarding across a removal.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [1:0] {
    SP_IO     = 2'b00,
    SP_ATTR   = 2'b01,
    SP_COMMON = 2'b10,
    SP_NONE   = 2'b11
  } space_e;

  localparam logic [31:0] SLOT_ONE_BASE = 32'h3000_0000;

  // Window number (top two region bits) to card space code.
  function automatic space_e window_to_space(input logic [1:0] win);
    space_e sp;
    case (win)
      2'd0:    sp = SP_IO;
      2'd2:    sp = SP_ATTR;
      2'd3:    sp = SP_COMMON;
      default: sp = SP_NONE;
    endcase
    return sp;
  endfunction

endpackage

// File: rtl/pcb_window_decode.sv
module pcb_window_decode
  import pcb_pkg::*;
#(
  parameter int CARD_AW = 26
) (
  input  logic [CARD_AW+1:0] addr_i,
  output space_e             space_o,
  output logic               hit_o,
  output logic [CARD_AW-1:0] offset_o
);

  localparam int WIN_LSB = CARD_AW;

  logic [1:0] win;

  always_comb begin
    win      = addr_i[WIN_LSB+1:WIN_LSB];
    space_o  = window_to_space(win);
    hit_o    = (space_o != SP_NONE);
    offset_o = addr_i[CARD_AW-1:0];
  end

endmodule

// File: rtl/pcb_access_pipe.sv
module pcb_access_pipe
  import pcb_pkg::*;
#(
  parameter int CARD_AW = 26,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  space_e             space_i,
  input  logic               hit_i,
  input  logic [CARD_AW-1:0] offset_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               present_i,
  output logic               card_stb_o,
  output logic               card_we_o,
  output space_e             card_space_o,
  output logic [CARD_AW-1:0] card_addr_o,
  output logic [DATA_W-1:0]  card_wdata_o,
  input  logic [DATA_W-1:0]  card_rdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o
);

  logic accept;
  logic pass;
  logic pend_q;

  assign accept = req_valid_i && req_ready_o;
  assign pass   = accept && hit_i && present_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready_o  <= 1'b0;
      card_stb_o   <= 1'b0;
      card_we_o    <= 1'b0;
      card_space_o <= SP_IO;
      card_addr_o  <= '0;
      card_wdata_o <= '0;
      pend_q       <= 1'b0;
    end else begin
      req_ready_o <= 1'b1;
      pend_q      <= accept;
      card_stb_o  <= pass;
      if (pass) begin
        card_we_o    <= req_write_i;
        card_space_o <= space_i;
        card_addr_o  <= offset_i;
        card_wdata_o <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= pend_q;
      if (pend_q && card_stb_o && !card_we_o) rsp_rdata_o <= card_rdata_i;
      else                                    rsp_rdata_o <= '0;
    end
  end

  // R5
  stb_space_valid_chk: assert property (@(posedge clk) disable iff (rst)
    card_stb_o |-> card_space_o != SP_NONE);

  // R4
  stb_needs_card_chk: assert property (@(posedge clk) disable iff (rst)
    card_stb_o |-> $past(present_i));

  // R3
  stb_then_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    card_stb_o |=> rsp_valid_o);

endmodule

// File: rtl/pcb_slot_ctrl.sv
module pcb_slot_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ins_i,
  input  logic ej_i,
  input  logic card_irq_i,
  output logic present_o,
  output logic err_o,
  output logic cd_irq_o,
  output logic host_irq_o
);

  logic ins_ok, ej_ok, nxt_present, nxt_err;

  always_comb begin
    ins_ok      = ins_i && !present_o;
    ej_ok       = ej_i && present_o;
    nxt_err     = (ins_i && present_o) || (ej_i && !present_o);
    nxt_present = present_o;
    if (ins_ok) nxt_present = 1'b1;
    if (ej_ok)  nxt_present = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      present_o  <= 1'b0;
      err_o      <= 1'b0;
      cd_irq_o   <= 1'b0;
      host_irq_o <= 1'b0;
    end else begin
      present_o  <= nxt_present;
      err_o      <= nxt_err;
      host_irq_o <= nxt_present && card_irq_i;
      if (ins_ok)     cd_irq_o <= 1'b1;
      else if (ej_ok) cd_irq_o <= 1'b0;
    end
  end

  // R6
  insert_sets_cd_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_i && !present_o && !ej_i) |=> (present_o && cd_irq_o && !err_o));

  // R7
  double_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_i && present_o && !ej_i) |=> (present_o && err_o));

  // R9
  empty_eject_chk: assert property (@(posedge clk) disable iff (rst)
    (ej_i && !present_o && !ins_i) |=> (err_o && !present_o));

  // R8
  eject_lowers_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(present_o) |-> (!cd_irq_o && !host_irq_o));

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    host_irq_o |-> present_o);

endmodule

// File: rtl/pccard_window_bridge.sv
module pccard_window_bridge
  import pcb_pkg::*;
#(
  parameter int          CARD_AW     = 26,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] SOCKET_BASE = 32'h2000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req_valid,
  output logic               host_req_ready,
  input  logic               host_req_write,
  input  logic [CARD_AW+1:0] host_req_addr,
  input  logic [DATA_W-1:0]  host_req_wdata,
  output logic               host_rsp_valid,
  output logic [DATA_W-1:0]  host_rsp_rdata,
  output logic               card_stb,
  output logic               card_we,
  output logic [1:0]         card_space,
  output logic [CARD_AW-1:0] card_addr,
  output logic [DATA_W-1:0]  card_wdata,
  input  logic [DATA_W-1:0]  card_rdata,
  input  logic               card_irq_in,
  input  logic               slot_insert,
  input  logic               slot_eject,
  output logic               slot_err,
  output logic               slot_present,
  output logic               cd_irq,
  output logic               host_card_irq,
  output logic               socket_index
);

  localparam logic IS_SLOT_ONE = (SOCKET_BASE == SLOT_ONE_BASE);

  space_e             dec_space;
  logic               dec_hit;
  logic [CARD_AW-1:0] dec_offset;
  space_e             out_space;

  pcb_window_decode #(.CARD_AW(CARD_AW)) u_decode (
    .addr_i   (host_req_addr),
    .space_o  (dec_space),
    .hit_o    (dec_hit),
    .offset_o (dec_offset)
  );

  pcb_slot_ctrl u_slot (
    .clk        (clk),
    .rst        (rst),
    .ins_i      (slot_insert),
    .ej_i       (slot_eject),
    .card_irq_i (card_irq_in),
    .present_o  (slot_present),
    .err_o      (slot_err),
    .cd_irq_o   (cd_irq),
    .host_irq_o (host_card_irq)
  );

  pcb_access_pipe #(.CARD_AW(CARD_AW), .DATA_W(DATA_W)) u_pipe (
    .clk          (clk),
    .rst          (rst),
    .req_valid_i  (host_req_valid),
    .req_ready_o  (host_req_ready),
    .req_write_i  (host_req_write),
    .space_i      (dec_space),
    .hit_i        (dec_hit),
    .offset_i     (dec_offset),
    .wdata_i      (host_req_wdata),
    .present_i    (slot_present),
    .card_stb_o   (card_stb),
    .card_we_o    (card_we),
    .card_space_o (out_space),
    .card_addr_o  (card_addr),
    .card_wdata_o (card_wdata),
    .card_rdata_i (card_rdata),
    .rsp_valid_o  (host_rsp_valid),
    .rsp_rdata_o  (host_rsp_rdata)
  );

  assign card_space   = out_space;
  assign socket_index = IS_SLOT_ONE;

endmodule

// File: tb/pccard_window_bridge_bench.sv
module pccard_window_bridge_bench;

  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic          req_valid, req_ready, req_write;
  logic [AW+1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, c_wdata, c_rdata;
  logic          rsp_valid, c_stb, c_we;
  logic [1:0]    c_space;
  logic [AW-1:0] c_addr;
  logic          irq_in, ins, ej, err, present, cdi, hirq, sock_idx;

  logic          z_ready, z_rv, z_stb, z_we, z_err, z_pres, z_cd, z_hirq, z_idx;
  logic [DW-1:0] z_rdata, z_wdata;
  logic [1:0]    z_space;
  logic [AW-1:0] z_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  function automatic logic [31:0] card_model(input logic [1:0] sp, input logic [AW-1:0] a);
    return 32'hC0DE_0000 | (32'(sp) << 8) | 32'(a);
  endfunction

  assign c_rdata = card_model(c_space, c_addr);

  pccard_window_bridge #(.CARD_AW(AW), .DATA_W(DW), .SOCKET_BASE(32'h3000_0000)) u_pccard_window_bridge (
    .clk(clk), .rst(rst),
    .host_req_valid(req_valid), .host_req_ready(req_ready), .host_req_write(req_write),
    .host_req_addr(req_addr), .host_req_wdata(req_wdata),
    .host_rsp_valid(rsp_valid), .host_rsp_rdata(rsp_rdata),
    .card_stb(c_stb), .card_we(c_we), .card_space(c_space), .card_addr(c_addr),
    .card_wdata(c_wdata), .card_rdata(c_rdata), .card_irq_in(irq_in),
    .slot_insert(ins), .slot_eject(ej), .slot_err(err), .slot_present(present),
    .cd_irq(cdi), .host_card_irq(hirq), .socket_index(sock_idx)
  );

  pccard_window_bridge #(.CARD_AW(AW), .DATA_W(DW)) u_sock0 (
    .clk(clk), .rst(rst),
    .host_req_valid(1'b0), .host_req_ready(z_ready), .host_req_write(1'b0),
    .host_req_addr('0), .host_req_wdata('0),
    .host_rsp_valid(z_rv), .host_rsp_rdata(z_rdata),
    .card_stb(z_stb), .card_we(z_we), .card_space(z_space), .card_addr(z_addr),
    .card_wdata(z_wdata), .card_rdata('0), .card_irq_in(1'b0),
    .slot_insert(1'b0), .slot_eject(1'b0), .slot_err(z_err), .slot_present(z_pres),
    .cd_irq(z_cd), .host_card_irq(z_hirq), .socket_index(z_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int a, input bit pres);
    logic [1:0]    win;
    bit            hit, exp_stb;
    logic [1:0]    code;
    logic [AW-1:0] off;
    logic [31:0]   wd, exp_rd;
    win  = 2'(a >> AW);
    off  = AW'(a);
    hit  = (win != 2'd1);
    code = (win == 2'd0) ? 2'b00 : (win == 2'd2) ? 2'b01 : 2'b10;
    wd   = 32'h5A5A_0000 | 32'(a);
    exp_stb = hit && pres;
    exp_rd  = (!wr && exp_stb) ? card_model(code, off) : 32'h0;
    chk(req_ready == 1'b1, "R3 ready", 32'(req_ready), 32'h1);
    req_valid = 1'b1; req_write = wr; req_addr = (AW+2)'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    // R4 R5: strobe only for a present card and a non-reserved window
    chk(c_stb == exp_stb, pres ? "R5 strobe" : "R4 strobe", 32'(c_stb), 32'(exp_stb));
    if (exp_stb) begin
      // R1 R2
      chk(c_space == code, "R1 space code", 32'(c_space), 32'(code));
      chk(c_addr == off && c_we == wr, "R2 card addr", 32'(c_addr), 32'(off));
      if (wr) chk(c_wdata == wd, "R2 wdata", c_wdata, wd);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b1 && c_stb == 1'b0, "R3 response", 32'(rsp_valid), 32'h1);
    chk(rsp_rdata == exp_rd, pres ? "R1 read data" : "R4 read data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R3 single pulse", 32'(rsp_valid), 32'h0);
  endtask

  task automatic event_step(input bit i, input bit e);
    ins = i; ej = e;
    @(negedge clk);
    ins = 1'b0; ej = 1'b0;
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    irq_in = 0; ins = 0; ej = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12
    chk(!present && !cdi && !hirq && !err && !c_stb && !rsp_valid, "R12 reset",
        {26'd0, present, cdi, hirq, err, c_stb, rsp_valid}, 32'h0);
    // R11
    chk(sock_idx == 1'b1, "R11 socket one", 32'(sock_idx), 32'h1);
    chk(z_idx == 1'b0, "R11 socket zero", 32'(z_idx), 32'h0);

    // R9
    event_step(0, 1);
    chk(err && !present, "R9 eject empty", {30'd0, err, present}, 32'h2);
    @(negedge clk);
    chk(!err, "R9 err one cycle", 32'(err), 32'h0);

    // R10: irq while empty stays low
    irq_in = 1'b1;
    @(negedge clk);
    chk(!hirq, "R10 gated when empty", 32'(hirq), 32'h0);
    irq_in = 1'b0;

    // Empty slot sweep
    for (int a = 0; a < (1 << (AW + 2)); a++) begin
      access(1, a, 0);
      access(0, a, 0);
    end

    // R6
    event_step(1, 0);
    chk(present && cdi && !err, "R6 insert", {29'd0, present, cdi, err}, 32'h6);
    // R7
    event_step(1, 0);
    chk(present && cdi && err, "R7 double insert", {29'd0, present, cdi, err}, 32'h7);
    @(negedge clk);
    chk(!err && present, "R7 err one cycle", {30'd0, err, present}, 32'h1);

    // Present slot sweep
    for (int a = 0; a < (1 << (AW + 2)); a++) begin
      access(1, a, 1);
      access(0, a, 1);
    end

    // R10 pass-through
    irq_in = 1'b1;
    @(negedge clk);
    chk(hirq, "R10 irq high", 32'(hirq), 32'h1);
    irq_in = 1'b0;
    @(negedge clk);
    chk(!hirq, "R10 irq low", 32'(hirq), 32'h0);
    irq_in = 1'b1;
    @(negedge clk);
    // R8
    event_step(0, 1);
    chk(!present && !cdi && !hirq && !err, "R8 eject", {28'd0, present, cdi, hirq, err}, 32'h0);
    @(negedge clk);
    chk(!hirq, "R10 irq after eject", 32'(hirq), 32'h0);
    irq_in = 1'b0;

    // R4 after removal
    access(0, 2 << AW, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule